// File: doc/BRIEF.md
# Charlieplexed Indicator Scan Driver

This block lights up to twelve indicator LEDs from only four tri-state pins. Each LED sits between an ordered pair of pins. It glows when its anode pin is driven high, its cathode pin is driven low, and the remaining two pins float. Only one such pair can be safely driven at a time. The block therefore steps through the twelve possible pairs in a fixed rotation. It energises a pair only when the corresponding bit of a 12-bit request mask is set. Because of persistence of vision, every requested LED appears lit together.

The LEDs form four groups of three, one group per anode pin. A one-hot phase register names the active group. A small sub-slot counter picks which of the other three pins acts as cathode. A prescaler sets how many clock cycles each slot lasts, typically about a millisecond. The request mask is captured only at slot boundaries, so a slot is never driven partially. The outputs are a per-pin drive enable and a per-pin drive level, intended for a tri-state pad.

Top module: `led_scan_driver`

## Requirements
- R1: While `rst_n` is low, and on the clock edge that ends reset, all pins are released: `pin_oe` and `pin_lvl` are all zero.
- R2: LED n has group g = n/3 and sub-slot s = n%3. Its anode is pin g, and its cathode is pin s when s < g, otherwise pin s+1. When LED n is driven, `pin_oe` has exactly the anode and cathode bits set, `pin_lvl` has only the anode bit set, and undriven pins always show level 0.
- R3: Slots run in the order LED 0, 1, ..., 11 and then repeat. The internal one-hot phase starts at 1000, which selects group 0. It rotates to 0100, 0010 and 0001 after every third slot, and then reloads 1000.
- R4: Each slot lasts exactly TICK_CYCLES clock cycles. Slot 0 begins in the first cycle after reset is released.
- R5: A slot drives its pin pair only if the mask bit of its LED is set. Otherwise all four pins are released for the whole slot.
- R6: At every cycle, `pin_oe` has either zero or exactly two bits set, so at most one LED is driven.
- R7: The mask is sampled when a slot begins; for slot 0, the mask in the last reset cycle is used. A mask change in the middle of a slot has no effect until the next slot starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| led_mask | input | 12 | Request mask, bit n asks LED n to appear lit |
| pin_oe | output | 4 | Per-pin drive enable, 0 = high impedance |
| pin_lvl | output | 4 | Per-pin drive level, valid where enabled |

## Verification
The bench builds the driver with four pins and TICK_CYCLES set to 5. A full twelve-slot frame then takes only 60 cycles. This puts the phase wrap from 0001 back to 1000, the slot edges, and mask changes inside a slot within a short run. With the default 50000-cycle tick these could not be checked cycle by cycle. Every cycle is compared with a pin model computed from the LED numbering. Several masks are used, including single-bit masks at both ends, an empty mask, and a reset applied in the middle of a frame.

// File: rtl/led_scan_pkg.sv
// Shared helpers for the LED scan driver.
// Assumes ordered pin pairs: an LED's group is its anode pin, and its
// cathode is chosen among the other pins in ascending order.
package led_scan_pkg;

    // Cathode pin for a given anode group and sub-slot (skips the anode pin).
    function automatic int cathode_of(input int grp, input int sub);
        return (sub < grp) ? sub : sub + 1;
    endfunction

endpackage

// File: rtl/scan_tick_gen.sv
// Slot prescaler: emits a one-cycle tick on the last cycle of every slot.
// Assumes TICK_CYCLES >= 1; the counter only runs once scanning is active.
module scan_tick_gen #(
    parameter int TICK_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Count cycles within the current slot, wrapping at the slot end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (run)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/scan_slot_seq.sv
// Slot sequencer: holds the one-hot group phase and the sub-slot counter.
// The phase starts at 1000 (group 0) and rotates right after the last
// sub-slot of each group. The run flag marks the first cycle after reset.
module scan_slot_seq #(
    parameter int PIN_COUNT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    output logic                 run,
    output logic [PIN_COUNT-1:0] phase,
    output logic [SW-1:0]        sub
);
    localparam int SUBS = PIN_COUNT - 1;
    localparam int SW   = (SUBS > 1) ? $clog2(SUBS) : 1;
    localparam logic [SW-1:0] LAST_SUB = SW'(SUBS - 1);

    // Scanning becomes active on the first edge after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 1'b0;
        else        run <= 1'b1;
    end

    // Advance the sub-slot each tick and rotate the phase when a group ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= {1'b1, {(PIN_COUNT-1){1'b0}}};
            sub   <= '0;
        end else if (tick) begin
            if (sub == LAST_SUB) begin
                sub   <= '0;
                phase <= {phase[0], phase[PIN_COUNT-1:1]};
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scan_pin_decode.sv
// Pin decoder: snapshots the mask at slot boundaries, gates the current
// slot with it, and turns the selected LED into pin enables and levels.
// Assumes phase is one-hot, with its MSB standing for group 0.
module scan_pin_decode #(
    parameter int PIN_COUNT = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                tick,
    input  logic                                run,
    input  logic [PIN_COUNT-1:0]                phase,
    input  logic [SW-1:0]                       sub,
    input  logic [PIN_COUNT*(PIN_COUNT-1)-1:0]  mask_in,
    output logic [PIN_COUNT-1:0]                pin_oe,
    output logic [PIN_COUNT-1:0]                pin_lvl
);
    import led_scan_pkg::*;

    localparam int SUBS = PIN_COUNT - 1;
    localparam int SW   = (SUBS > 1) ? $clog2(SUBS) : 1;
    localparam int LEDS = PIN_COUNT * SUBS;

    logic [LEDS-1:0]      mask_q;
    logic [PIN_COUNT-1:0] grp_sel;
    logic [PIN_COUNT-1:0] lit_vec;
    logic [PIN_COUNT-1:0] cath_vec;
    logic                 hit;

    // Capture the request mask during reset and at every slot boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= mask_in;
        else if (tick) mask_q <= mask_in;
    end

    // Reorder the phase so that index g means group g (anode pin g).
    for (genvar g = 0; g < PIN_COUNT; g++) begin : g_grp
        assign grp_sel[g] = phase[PIN_COUNT-1-g];
    end

    // Pick each group's mask bit for the current sub-slot and AND with phase.
    always_comb begin
        for (int g = 0; g < PIN_COUNT; g++)
            lit_vec[g] = mask_q[g*SUBS + int'(sub)];
        hit = |(grp_sel & lit_vec);
    end

    // Find the cathode pin of the active group for the current sub-slot.
    always_comb begin
        cath_vec = '0;
        for (int g = 0; g < PIN_COUNT; g++)
            if (grp_sel[g])
                for (int p = 0; p < PIN_COUNT; p++)
                    if (cathode_of(g, int'(sub)) == p)
                        cath_vec[p] = 1'b1;
    end

    // Per-pin drive: anode high, cathode low, all others released.
    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
        assign pin_oe[p]  = run & hit & (grp_sel[p] | cath_vec[p]);
        assign pin_lvl[p] = run & hit & grp_sel[p];
    end
endmodule

// File: rtl/led_scan_driver.sv
// Top of the multiplexed LED scan driver: prescaler, slot sequencer and
// pin decoder. Assumes a synchronous active-low reset held at least two
// cycles.
module led_scan_driver #(
    parameter int PIN_COUNT   = 4,
    parameter int TICK_CYCLES = 50000
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [PIN_COUNT*(PIN_COUNT-1)-1:0] led_mask,
    output logic [PIN_COUNT-1:0]               pin_oe,
    output logic [PIN_COUNT-1:0]               pin_lvl
);
    localparam int SUBS = PIN_COUNT - 1;
    localparam int SW   = (SUBS > 1) ? $clog2(SUBS) : 1;

    logic                 slot_tick;
    logic                 scan_run;
    logic [PIN_COUNT-1:0] scan_phase;
    logic [SW-1:0]        scan_sub;

    scan_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(scan_run), .tick(slot_tick)
    );

    scan_slot_seq #(.PIN_COUNT(PIN_COUNT)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(slot_tick),
        .run(scan_run), .phase(scan_phase), .sub(scan_sub)
    );

    scan_pin_decode #(.PIN_COUNT(PIN_COUNT)) u_dec (
        .clk(clk), .rst_n(rst_n), .tick(slot_tick), .run(scan_run),
        .phase(scan_phase), .sub(scan_sub), .mask_in(led_mask),
        .pin_oe(pin_oe), .pin_lvl(pin_lvl)
    );
endmodule

// File: rtl/led_scan_driver_chk.sv
// Property checker for the scan driver, bound to every instance of the top.
module led_scan_driver_chk #(
    parameter int PIN_COUNT = 4,
    parameter int SW        = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic                 run,
    input logic [PIN_COUNT-1:0] phase,
    input logic [SW-1:0]        sub,
    input logic [PIN_COUNT-1:0] pin_oe,
    input logic [PIN_COUNT-1:0] pin_lvl
);
    localparam logic [SW-1:0] LAST_SUB = SW'(PIN_COUNT - 2);

    // R6
    at_most_one_led_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe == '0) || ($countones(pin_oe) == 2));

    // R2
    level_only_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_lvl & ~pin_oe) == '0);

    // R2
    single_anode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe != '0) |-> ($countones(pin_lvl) == 1));

    // R3
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1);

    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));

    // R3
    phase_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sub == LAST_SUB) |=> !$stable(phase));

    // R7
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run) && !$past(tick)) |->
            ($stable(pin_oe) && $stable(pin_lvl)));
endmodule

bind led_scan_driver led_scan_driver_chk #(.PIN_COUNT(PIN_COUNT), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(slot_tick), .run(scan_run),
    .phase(scan_phase), .sub(scan_sub), .pin_oe(pin_oe), .pin_lvl(pin_lvl)
);

// File: tb/led_scan_driver_bench.sv
// Directed bench for the LED scan driver; each task checks its own results.
module led_scan_driver_bench;
    localparam int T = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] led_mask = '0;
    logic [3:0]  pin_oe;
    logic [3:0]  pin_lvl;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    led_scan_driver #(.PIN_COUNT(4), .TICK_CYCLES(T)) u_led_scan_driver (
        .clk(clk), .rst_n(rst_n), .led_mask(led_mask),
        .pin_oe(pin_oe), .pin_lvl(pin_lvl)
    );

    // Expected {oe, lvl} for slot k counted from reset, under mask m (R2, R3, R5).
    function automatic logic [7:0] exp_pins(input int k, input logic [11:0] m);
        int g = (k / 3) % 4;
        int s = k % 3;
        int c = (s < g) ? s : s + 1;
        logic [3:0] oe;
        logic [3:0] lv;
        if (!m[g*3 + s]) return 8'h00;
        oe = (4'b1 << g) | (4'b1 << c);
        lv = 4'b1 << g;
        return {oe, lv};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R1: hold reset with mask m; pins must stay released; release at a negedge.
    task automatic apply_reset(input logic [11:0] m);
        @(negedge clk);
        rst_n = 1'b0;
        led_mask = m;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1 reset releases pins", {pin_oe, pin_lvl}, 8'h00);
        end
        rst_n = 1'b1;
    endtask

    // Check every cycle of slots first..first+n-1 against mask m; one check per slot.
    task automatic run_slots(input int first, input int n, input logic [11:0] m, input string req);
        for (int k = first; k < first + n; k++) begin
            logic [7:0] bad_act = 8'h00;
            logic [7:0] bad_exp = 8'h00;
            logic       bad = 1'b0;
            for (int c = 0; c < T; c++) begin
                @(negedge clk);
                if (!bad && {pin_oe, pin_lvl} !== exp_pins(k, m)) begin
                    bad = 1'b1;
                    bad_act = {pin_oe, pin_lvl};
                    bad_exp = exp_pins(k, m);
                end
                if (!($countones(pin_oe) == 0 || $countones(pin_oe) == 2)) begin
                    checks++; errors++;
                    $display("FAIL R6: actual oe %b expected 0 or 2 bits", pin_oe);
                end
            end
            chk(req, bad ? bad_act : exp_pins(k, m), bad ? bad_exp : exp_pins(k, m));
        end
    endtask

    // R2 R3: full mask, 14 slots so the phase wraps back to group 0.
    task automatic t_full_scan();
        apply_reset(12'hFFF);
        run_slots(0, 14, 12'hFFF, "R2 R3 full-mask scan order");
    endtask

    // R4: only LED 0 requested; it is lit for exactly T cycles from the first cycle.
    task automatic t_slot_length();
        int lit = 0;
        int first_lit = -1;
        apply_reset(12'h001);
        for (int c = 0; c < 12 * T; c++) begin
            @(negedge clk);
            if (pin_oe != 4'b0000) begin
                lit++;
                if (first_lit < 0) first_lit = c;
            end
        end
        chk("R4 slot length", 8'(lit), 8'(T));
        chk("R4 first slot starts after reset", 8'(first_lit), 8'h00);
    endtask

    // R5: several mask patterns gate the slots.
    task automatic t_patterns();
        logic [11:0] pats [4] = '{12'hA5C, 12'h800, 12'h000, 12'h3C3};
        foreach (pats[i]) begin
            apply_reset(pats[i]);
            run_slots(0, 13, pats[i], "R5 mask gating");
        end
    endtask

    // R7: mask changes mid-slot take effect only at the next slot.
    task automatic t_mid_change();
        apply_reset(12'hFFF);
        run_slots(0, 1, 12'hFFF, "R7 before change");
        for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            chk("R7 slot 1 early", {pin_oe, pin_lvl}, exp_pins(1, 12'hFFF));
        end
        led_mask = 12'h000;
        for (int c = 2; c < T; c++) begin
            @(negedge clk);
            chk("R7 mid-slot clear ignored", {pin_oe, pin_lvl}, exp_pins(1, 12'hFFF));
        end
        run_slots(2, 2, 12'h000, "R7 clear applied at boundary");
        @(negedge clk);
        chk("R7 slot 4 start dark", {pin_oe, pin_lvl}, 8'h00);
        led_mask = 12'hFFF;
        for (int c = 1; c < T; c++) begin
            @(negedge clk);
            chk("R7 mid-slot set ignored", {pin_oe, pin_lvl}, 8'h00);
        end
        run_slots(5, 2, 12'hFFF, "R7 set applied at boundary");
    endtask

    // R1 R3: reset in mid-frame restarts the scan at LED 0.
    task automatic t_reset_midrun();
        apply_reset(12'hFFF);
        run_slots(0, 7, 12'hFFF, "R3 before re-reset");
        apply_reset(12'h0F0);
        run_slots(0, 12, 12'h0F0, "R1 R3 restart at LED 0");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_full_scan();
        t_slot_length();
        t_patterns();
        t_mid_change();
        t_reset_midrun();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule